// File: doc/BRIEF.md
# Self-Correcting One-Hot Ring Counter

This block is a four-stage timing-sequence generator. A single set bit walks from the lowest stage to the highest stage, one stage per enabled clock, then wraps back to the lowest stage. The four outputs can be used directly as phase strobes, for example to step a four-slot schedule. An encoded phase number and a legality flag come from the same state.

The wrap does not copy the top stage straight back to the bottom. The bottom stage instead loads the NOR of the three lower stages. In the legal cycle this gives the same result as a plain wrap. From any corrupted pattern, including all-zero and patterns with several bits set, the counter works its way back into the one-hot cycle within four enabled clocks, with no reset needed.

A synchronous seed port loads an arbitrary pattern into the stages. It is used to start the sequence at a chosen phase, and to place the counter in an illegal pattern so that recovery can be exercised.

Top module: `ring_selfcorr_ctr`

## Requirements
- R1: With `rst` high at a rising clock edge, the state becomes 0001 (`state[0]` set, the rest clear) on that edge.
- R2: In a legal state, each enabled edge (`en`=1, `seed_en`=0) moves the set bit one position up: 0001, 0010, 0100, 1000, then 0001 again. The cycle repeats for as long as the counter is enabled.
- R3: With `en`=0, `seed_en`=0 and `rst`=0, every stage keeps its value across the edge.
- R4: `rst` takes priority over `seed_en` and `en`. `seed_en` takes priority over `en`.
- R5: With `seed_en`=1 and `rst`=0, the edge loads `seed_val` into the state whatever the value of `en`.
- R6: From the all-zero state, one enabled edge gives 0001.
- R7: From each of the 16 possible patterns, the state is one-hot after at most four enabled edges. Once one-hot, it stays one-hot on every later enabled edge.
- R8: `phase_ok` is high exactly when one stage bit is set. `phase_idx` then gives the bit position of that set bit (0 for `state[0]`, up to 3 for `state[3]`). When `phase_ok` is low, `phase_idx` is 0.
- R9: On each enabled edge, including from illegal patterns, `state[3:1]` takes the old `state[2:0]`, and `state[0]` takes the complement of the OR of the old `state[2:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, sets state 0001 |
| en | input | 1 | Advance enable; when low the state holds |
| seed_en | input | 1 | Synchronous load of `seed_val` into the stages |
| seed_val | input | 4 | Pattern to load, bit i into stage i |
| state | output | 4 | Stage outputs, usable directly as per-phase strobes |
| phase_idx | output | 2 | Position of the set stage when legal, else 0 |
| phase_ok | output | 1 | High when exactly one stage is set |

## Verification
A bad feedback or shift path in this block shows up at `state` on the very next enabled edge. The bench compares each stage after one edge from every seeded pattern, so such a fault is caught in one cycle. A fault that only slows recovery or breaks the wrap shows up later. `phase_ok` either stays low past the fourth enabled edge, or the bit fails to come back to position 0 within four edges of reaching position 3. The bench catches these by counting edges to the first one-hot state and then following the rotation over two full turns. A decoder fault shows as a `phase_idx` or `phase_ok` value that disagrees with `state` in the same cycle.

// File: rtl/ring_pkg.sv
package ring_pkg;
    localparam int STAGES = 4;
    localparam int IDX_W  = $clog2(STAGES);
    localparam int CNT_W  = IDX_W + 1;

    typedef logic [STAGES-1:0] ring_vec_t;

    typedef struct packed {
        ring_vec_t stages;
    } ring_state_t;

    localparam ring_vec_t RESET_PATTERN = ring_vec_t'(1);
endpackage

// File: rtl/ring_feedback.sv
module ring_feedback
    import ring_pkg::*;
(
    input  ring_vec_t cur,
    output ring_vec_t advanced
);
    logic serial_in;

    // Lower stages drive the serial input; the top stage is left out so that
    // a set bit arriving there wraps to zero patterns below it.
    assign serial_in = ~|cur[STAGES-2:0];

    assign advanced[0] = serial_in;
    for (genvar g = 1; g < STAGES; g++) begin : g_shift
        assign advanced[g] = cur[g-1];
    end
endmodule

// File: rtl/ring_phase_decode.sv
module ring_phase_decode
    import ring_pkg::*;
(
    input  ring_vec_t        vec,
    output logic [IDX_W-1:0] idx,
    output logic             ok
);
    logic [CNT_W-1:0] ones;
    logic [IDX_W-1:0] pos;

    always_comb begin
        ones = '0;
        pos  = '0;
        for (int i = 0; i < STAGES; i++) begin
            if (vec[i]) begin
                ones = ones + CNT_W'(1);
                pos  = IDX_W'(i);
            end
        end
        ok  = (ones == CNT_W'(1));
        idx = ok ? pos : '0;
    end
endmodule

// File: rtl/ring_selfcorr_ctr.sv
module ring_selfcorr_ctr
    import ring_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic                      seed_en,
    input  logic [ring_pkg::STAGES-1:0] seed_val,
    output logic [ring_pkg::STAGES-1:0] state,
    output logic [ring_pkg::IDX_W-1:0]  phase_idx,
    output logic                      phase_ok
);
    ring_state_t ctr_d, ctr_q;
    ring_vec_t   step_vec;

    ring_feedback u_fb (
        .cur      (ctr_q.stages),
        .advanced (step_vec)
    );

    always_comb begin
        ctr_d = ctr_q;
        if (rst) begin
            ctr_d.stages = RESET_PATTERN;
        end else if (seed_en) begin
            ctr_d.stages = seed_val;
        end else if (en) begin
            ctr_d.stages = step_vec;
        end
    end

    always_ff @(posedge clk) begin
        ctr_q <= ctr_d;
    end

    assign state = ctr_q.stages;

    ring_phase_decode u_dec (
        .vec (ctr_q.stages),
        .idx (phase_idx),
        .ok  (phase_ok)
    );

    AST_RESET_ONEHOT: assert property (@(posedge clk)
        rst |=> (state == 4'b0001)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!en && !seed_en) |=> $stable(state)); // R3
    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
        seed_en |=> (state == $past(seed_val))); // R5
    AST_UPPER_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (en && !seed_en) |=> (state[3:1] == $past(state[2:0]))); // R9
    AST_LOW_FEED: assert property (@(posedge clk) disable iff (rst)
        (en && !seed_en) |=> (state[0] == !($past(state[0]) || $past(state[1]) || $past(state[2])))); // R9
    AST_LEGAL_KEPT: assert property (@(posedge clk) disable iff (rst)
        (phase_ok && !seed_en) |=> phase_ok); // R7
    AST_OK_MATCH: assert property (@(posedge clk) disable iff (rst)
        phase_ok == ($countones(state) == 1)); // R8
endmodule

// File: tb/tb_ring_selfcorr_ctr.sv
module tb_ring_selfcorr_ctr;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic       seed_en;
    logic [3:0] seed_val;
    logic [3:0] state;
    logic [1:0] phase_idx;
    logic       phase_ok;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_selfcorr_ctr dut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .seed_en   (seed_en),
        .seed_val  (seed_val),
        .state     (state),
        .phase_idx (phase_idx),
        .phase_ok  (phase_ok)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int pos_of(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic check_decode(input string req);
        logic legal;
        legal = ($countones(state) == 1);
        chk(phase_ok == legal, req, phase_ok, legal);
        chk(phase_idx == (legal ? pos_of(state) : 0), req, phase_idx, legal ? pos_of(state) : 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] held;
        logic [3:0] exp_v;
        int first_ok;
        rst = 1'b1; en = 1'b0; seed_en = 1'b0; seed_val = '0;
        #2;
        tick(); tick();
        // R1 reset value
        chk(state == 4'b0001, "R1", state, 1);
        check_decode("R8");
        rst = 1'b0;

        // R2 rotation over two turns
        en = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            tick();
            exp_v = 4'b0001 << (k % 4);
            chk(state == exp_v, "R2", state, exp_v);
            chk(phase_idx == (k % 4), "R8", phase_idx, k % 4);
        end

        // R3 hold while disabled
        en = 1'b0;
        held = state;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(state == held, "R3", state, held);
        end

        // R4 reset beats seed and enable
        rst = 1'b1; en = 1'b1; seed_en = 1'b1; seed_val = 4'b1111;
        tick();
        chk(state == 4'b0001, "R4", state, 1);
        rst = 1'b0;
        // R4 seed beats enable
        seed_val = 4'b0100;
        tick();
        chk(state == 4'b0100, "R4", state, 4'b0100);
        seed_en = 1'b0; en = 1'b0;

        for (int s = 0; s < 16; s++) begin
            // R5 seed load while disabled
            seed_en = 1'b1; seed_val = 4'(s); en = 1'b0;
            tick();
            chk(state == 4'(s), "R5", state, s);
            check_decode("R8");
            seed_en = 1'b0; en = 1'b1;

            // R9 one step from the seeded pattern
            tick();
            exp_v = {seed_val[2:0], ~|seed_val[2:0]};
            chk(state == exp_v, "R9", state, exp_v);
            if (s == 0) chk(state == 4'b0001, "R6", state, 1);
            first_ok = ($countones(state) == 1) ? 1 : 0;
            for (int k = 2; k <= 4; k++) begin
                tick();
                if (first_ok == 0 && $countones(state) == 1) first_ok = k;
            end
            // R7 recovery within four edges
            chk(first_ok != 0 && $countones(state) == 1, "R7", state, first_ok);

            // R7 / R2 stays legal and rotates afterwards
            for (int k = 0; k < 8; k++) begin
                held = state;
                tick();
                exp_v = {held[2:0], held[3]};
                chk(state == exp_v, "R2", state, exp_v);
                check_decode("R8");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule